// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block lets synchronous logic reach an asynchronous static RAM. The RAM side has an 8-bit shared data bus plus active-low chip select, write enable and output enable. The user side presents a one-cycle request carrying a direction flag, an address and write data. For reads it returns the data with a one-cycle valid strobe. A busy flag tells the requester when a new request can be taken.

Every pad-facing path is a flop clocked by the system clock, so each path can sit in an I/O-cell register. These paths are the address, the outgoing data, the three strobes, the tristate enable of the data bus and the first sampling of incoming data. The data bus is released to high impedance at all times except during the three cycles of a write.

Accesses have a fixed shape. A request is sampled on the edge that ends cycle 0. The access then occupies cycles 1 to 3, and cycle 4 is free for the next request. That cycle is also the one in which read data is returned.

Top module: `sramport_top`

## Requirements
- R1: After reset, sramCsN, sramWeN and sramOeN are 1, busy and rdValid are 0, and the data bus is not driven by the block.
- R2: A write accepted at the end of cycle 0 produces three bus cycles. In cycle 1, sramCsN=0, sramWeN=1 and sramOeN=1, and sramData carries the write data. In cycle 2, sramWeN=0. In cycle 3, sramWeN=1 while the data is still driven. In cycle 4, sramCsN=1.
- R3: A read accepted at the end of cycle 0 holds sramCsN=0, sramOeN=0 and sramWeN=1 for exactly two cycles (cycles 1 and 2). From cycle 3 on, sramCsN=1 and sramOeN=1.
- R4: For a read, rdValid is 1 for exactly one cycle (cycle 4). In that cycle rdData equals the value the RAM drove on the bus while sramOeN was 0.
- R5: busy is 1 in cycles 1 to 3 of each access and 0 otherwise. A request presented while busy is 1 is dropped. It leaves no trace on the RAM contents or on the later outputs.
- R6: The block never drives the data bus in a cycle where sramOeN=0. Between a read and a following write there is at least one cycle with neither sramOeN low nor the bus driven.
- R7: sramAddr is registered at acceptance and stays constant for every cycle in which sramCsN is 0, including the cycle after sramWeN rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when busy is 0 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| rdValid | output | 1 | One-cycle read data strobe |
| rdData | output | DATA_W | Read data |
| sramAddr | output | ADDR_W | Registered RAM address |
| sramData | inout | DATA_W | Shared RAM data bus |
| sramCsN | output | 1 | Chip select, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramOeN | output | 1 | Output enable, active low |

## Verification
Results are counted from the edge that accepts a request. The strobes and busy change in cycles 1 to 4 as listed above. Write data is on the bus in cycles 1 to 3, and read data and rdValid appear in cycle 4.

The bench runs a behavioural model that advances one phase per rising edge. It compares the model with every output at the falling edge, so each value is read half a cycle after the edge that should have produced it. A RAM model in the bench answers reads from its own array. Written values are checked by reading them back, and dropped requests are checked by reading back the address they named.

// File: rtl/sramport_pkg.sv
package sramport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RDONE
  } ctlState_t;

  // strobes from the sequencer to the pad datapath
  typedef struct packed {
    logic load;      // latch address and write data
    logic driveOn;   // set the tristate enable flop
    logic driveOff;  // clear the tristate enable flop
    logic capture;   // move sampled bus value to rdData
  } dpStrobe_t;

endpackage

// File: rtl/sramport_ctl.sv
module sramport_ctl
  import sramport_pkg::*;
#(
  parameter int RD_WAIT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       busy,
  output dpStrobe_t  strobe,
  output logic       sramCsN,
  output logic       sramWeN,
  output logic       sramOeN
);

  localparam int CNT_W = (RD_WAIT > 1) ? $clog2(RD_WAIT) : 1;

  ctlState_t  state;
  logic [CNT_W-1:0] waitCnt;
  logic       accept;

  assign accept = reqValid && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    strobe          = '0;
    strobe.load     = accept;
    strobe.driveOn  = accept && reqWrite;
    strobe.driveOff = (state == ST_WHOLD);
    strobe.capture  = (state == ST_RDONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      sramCsN <= 1'b1;
      sramWeN <= 1'b1;
      sramOeN <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            sramCsN <= 1'b0;
            if (reqWrite) begin
              state <= ST_WSETUP;
            end else begin
              sramOeN <= 1'b0;
              waitCnt <= CNT_W'(RD_WAIT - 1);
              state   <= ST_RACC;
            end
          end
        end
        ST_WSETUP: begin
          sramWeN <= 1'b0;
          state   <= ST_WPULSE;
        end
        ST_WPULSE: begin
          sramWeN <= 1'b1;
          state   <= ST_WHOLD;
        end
        ST_WHOLD: begin
          sramCsN <= 1'b1;
          state   <= ST_IDLE;
        end
        ST_RACC: begin
          if (waitCnt == '0) begin
            sramCsN <= 1'b1;
            sramOeN <= 1'b1;
            state   <= ST_RDONE;
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        ST_RDONE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R2: write enable low only inside a selected, output-disabled cycle
  a_r2_we_in_write: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (!sramCsN && sramOeN));

  // R2: write enable low for exactly one cycle
  a_r2_we_single: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |=> $rose(sramWeN));

  // R3: output enable low only with chip select low and write enable high
  a_r3_oe_in_read: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> (!sramCsN && sramWeN));

endmodule

// File: rtl/sramport_dp.sv
module sramport_dp
  import sramport_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [DATA_W-1:0] padIn;

  // pad-side flops: address, outgoing data, tristate enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sramAddr <= '0;
      dataOut  <= '0;
      driveEn  <= 1'b0;
    end else begin
      if (strobe.load) begin
        sramAddr <= reqAddr;
        dataOut  <= reqWdata;
      end
      if (strobe.driveOn)       driveEn <= 1'b1;
      else if (strobe.driveOff) driveEn <= 1'b0;
    end
  end

  // input pad flop samples every cycle, then feeds the user register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      padIn   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      padIn   <= busIn;
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= padIn;
    end
  end

  // R4: read strobe lasts a single cycle
  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R7: address frozen while the bus is driven
  a_r7_addr_while_drive: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && $past(driveEn)) |-> $stable(sramAddr));

endmodule

// File: rtl/sramport_top.sv
module sramport_top
  import sramport_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 8,
  parameter int RD_WAIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  inout  wire  [DATA_W-1:0] sramData,
  output logic              sramCsN,
  output logic              sramWeN,
  output logic              sramOeN
);

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] dataOut;
  logic              driveEn;

  sramport_ctl #(.RD_WAIT(RD_WAIT)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .busy     (busy),
    .strobe   (strobe),
    .sramCsN  (sramCsN),
    .sramWeN  (sramWeN),
    .sramOeN  (sramOeN)
  );

  sramport_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busIn    (sramData),
    .sramAddr (sramAddr),
    .dataOut  (dataOut),
    .driveEn  (driveEn),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  assign sramData = driveEn ? dataOut : {DATA_W{1'bz}};

  // R6: no driver fight between the RAM and the block
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramOeN && driveEn));

  // R2: data still driven in the cycle write enable returns high
  a_r2_data_after_we: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> driveEn);

  // R7: address constant across consecutive selected cycles
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCsN && !$past(sramCsN)) |-> $stable(sramAddr));

endmodule

// File: tb/sramport_top_tb.sv
module sramport_top_tb;

  localparam int AW = 10;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          busy, rdValid, sramCsN, sramWeN, sramOeN;
  logic [DW-1:0] rdData;
  logic [AW-1:0] sramAddr;
  wire  [DW-1:0] sramData;

  always #4 clk = ~clk;  // 125 MHz

  sramport_top #(.ADDR_W(AW), .DATA_W(DW), .RD_WAIT(2)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy), .rdValid(rdValid),
    .rdData(rdData), .sramAddr(sramAddr), .sramData(sramData),
    .sramCsN(sramCsN), .sramWeN(sramWeN), .sramOeN(sramOeN)
  );

  // RAM model
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] expMem [DEPTH];
  assign sramData = (!sramCsN && !sramOeN && sramWeN) ? mem[sramAddr] : {DW{1'bz}};
  always @(posedge sramWeN) if (sramCsN === 1'b0) mem[sramAddr] <= sramData;

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: phase 0 idle, 1..3 access, 4 first free cycle
  int            ph = 0;
  logic          mW = 1'b0;
  logic [AW-1:0] mA = '0;
  logic [DW-1:0] mD = '0;
  logic [DW-1:0] mRd = '0;

  always @(posedge clk) begin
    if (!rstN) ph = 0;
    else if (ph >= 1 && ph <= 3) ph = ph + 1;
    else if (reqValid) begin
      ph = 1; mW = reqWrite; mA = reqAddr; mD = reqWdata;
      if (mW) expMem[mA] = mD;
      else    mRd = expMem[mA];
    end else ph = 0;
  end

  int cycles = 0;
  bit timedOut = 0;

  always @(negedge clk) begin
    cycles++;
    if (rstN && !timedOut) begin
      logic inAcc, eCs, eWe, eOe, eValid;
      string tCtl;
      inAcc  = (ph >= 1 && ph <= 3);
      eCs    = mW ? !inAcc : !(ph == 1 || ph == 2);
      eWe    = !(mW && ph == 2);
      eOe    = !(!mW && (ph == 1 || ph == 2));
      eValid = (!mW && ph == 4);
      tCtl   = (ph == 0) ? "R1" : (mW ? "R2" : "R3");
      check("R5", "busy", {31'b0, busy}, {31'b0, inAcc});
      check(tCtl, "csN", {31'b0, sramCsN}, {31'b0, eCs});
      check(tCtl, "weN", {31'b0, sramWeN}, {31'b0, eWe});
      check(tCtl, "oeN", {31'b0, sramOeN}, {31'b0, eOe});
      check("R4", "rdValid", {31'b0, rdValid}, {31'b0, eValid});
      if (eValid) check("R4", "rdData", {24'b0, rdData}, {24'b0, mRd});
      if (!eCs)   check("R7", "addr", {22'b0, sramAddr}, {22'b0, mA});
      if (mW && inAcc) check("R2", "bus data", {24'b0, sramData}, {24'b0, mD});
      // R6: a foreign driver during a read would corrupt the RAM's value
      if (!mW && !eOe) check("R6", "bus during read", {24'b0, sramData}, {24'b0, mRd});
    end
    if (cycles > 20000 && !timedOut) begin
      timedOut = 1;
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected=<20000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // present a request for one cycle, then idle long enough for the access
  task automatic doReq(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]    = DW'(i) ^ 8'hA5;
      expMem[i] = DW'(i) ^ 8'hA5;
    end
    repeat (4) @(negedge clk);
    // R1: reset values, sampled while reset is still low
    check("R1", "reset csN", {31'b0, sramCsN}, 32'd1);
    check("R1", "reset weN", {31'b0, sramWeN}, 32'd1);
    check("R1", "reset oeN", {31'b0, sramOeN}, 32'd1);
    check("R1", "reset busy", {31'b0, busy}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    doReq(1'b1, 10'd0,    8'h3C);   // R2 write, lowest address
    doReq(1'b1, 10'd1023, 8'hFF);   // back to back, highest address
    doReq(1'b0, 10'd0,    8'h00);   // R4 read back
    doReq(1'b1, 10'd5,    8'h00);   // R6 write right after a read
    doReq(1'b0, 10'd1023, 8'h00);
    doReq(1'b0, 10'd5,    8'h00);
    doReq(1'b0, 10'd7,    8'h00);   // never written

    // R5: write accepted, then a second write held during the busy cycles
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 10'd9; reqWdata = 8'h11;
    @(negedge clk);
    reqAddr = 10'd10; reqWdata = 8'h77;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    doReq(1'b0, 10'd10, 8'h00);     // R5: must still hold its initial value
    doReq(1'b0, 10'd9,  8'h00);

    // request held high: re-accepted in each first free cycle
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 10'd1023;
    repeat (10) @(negedge clk);
    reqValid = 1'b0;
    repeat (6) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule